// File: doc/BRIEF.md
# PHY Test-Port Register Access Sequencer

This block turns single register requests into the pin-level handshake of a PHY test port. The port has one 8-bit input bus that carries first a register address and then a value. A level-sensitive enable tells the PHY which of the two it is looking at, and a slow test clock latches each one. Read results come back on a separate 8-bit output bus. The PHY needs some time to present the addressed register after the address phase ends, so the sequencer waits a programmable number of cycles before it samples that bus.

A requester supplies an address, write data, a read/write flag and a start strobe. It then watches busy and waits for a one-cycle done pulse, which comes with an error flag and the read result. Addresses and data on the request side are wider than a byte. Any request that does not fit in eight bits is refused at once and nothing on the test port moves. A separate command plays a clear pulse on the test-clear pin. The widths of the high and low halves of the test clock, and of the clear pulse, are set in system clocks by a configuration input. That value and the settle count are captured when a request is accepted.

Top module: `phy_tport_seq`

## Requirements
- R1: After reset, busy, done and err are low, rdata is 0x00, and the test clock, test enable and test clear pins are low.
- R2: A request whose address exceeds 0xFF, or a write whose data exceeds 0xFF, is refused. Done and err are high in the cycle after the accepting edge. Busy never rises, no test-clock pulse is produced and no PHY register changes.
- R3: A write drives the following sequence. First, test enable goes high with the address on the data-in bus and one test-clock pulse follows. Then test enable goes low with the write data on the data-in bus and a second pulse follows. Done is seen 2+4H cycles after the accepting edge.
- R4: A read performs only the address phase. It lowers test enable and samples the data-out bus at the (S+1)-th rising edge after the edge that lowered it. Rdata and done are seen 2+2H+S cycles after the accepting edge.
- R5: Every test-clock high and low half lasts H system clocks, where H is the half-width input and a value of 0 counts as 1. H and S are captured at acceptance, so later changes to them do not affect the access in progress.
- R6: Test enable and data-in hold their values for at least one system clock before every rising test-clock edge. Test enable changes only while the test clock is low.
- R7: A clear command holds test clear low for H cycles, high for H cycles and low for H cycles. Done is seen 3H cycles after acceptance. No test-clock pulse occurs during a clear, and test clear is low at all other times.
- R8: Start and clear commands are ignored while busy. If both arrive in the same idle cycle, the register request wins and test clear does not move.
- R9: Done lasts one cycle per access, busy is low whenever done is high, and err is high only together with done.
- R10: Rdata keeps the last captured read value until the next read completes. Writes, clears and refused requests leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Strobe that starts a register access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | REQ_W | Register address; only values up to 0xFF are accepted |
| req_wdata | input | REQ_W | Write value; only values up to 0xFF are accepted |
| clr_start | input | 1 | Strobe that starts a test-clear pulse |
| cfg_half | input | HALF_W | System clocks per test-clock half, with 0 counted as 1 |
| cfg_settle | input | SETTLE_W | Extra settle cycles before read sampling |
| busy | output | 1 | Access or clear in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused (valid with done) |
| rdata | output | 8 | Last captured read value |
| tp_clk | output | 1 | Test clock to PHY |
| tp_en | output | 1 | Test enable: high = address phase |
| tp_din | output | 8 | Shared address/data bus to PHY |
| tp_dout | input | 8 | Read data bus from PHY |
| tp_clr | output | 1 | Test clear to PHY |

## Verification
The bench models the PHY's latch behaviour. Its data-out bus shows the inverted register value until test enable has been low for three cycles. A settle count below that threshold therefore returns a value that can be told apart from a correct read, and reads with short and long settle counts show whether sampling waits as it should. The sequencer is exercised with the following patterns:
- directed writes and reads, each followed by a read-back;
- a half-width of zero;
- a configuration change in the middle of an access;
- refused addresses and refused data;
- start and clear strobes while busy, and both strobes in the same cycle;
- random mixes of reads and writes over different half-widths and settle counts.

Each access has its completion cycle and its read result checked, and the test-clock high width and setup are checked on every pulse.

// File: rtl/phy_tport_pkg.sv
package phy_tport_pkg;

    localparam int TP_BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADR_SETUP,
        ST_ADR_HIGH,
        ST_ADR_LOW,
        ST_DAT_SETUP,
        ST_DAT_HIGH,
        ST_DAT_LOW,
        ST_SETTLE,
        ST_CLR_LOW1,
        ST_CLR_HIGH,
        ST_CLR_LOW2
    } tp_state_e;

endpackage

// File: rtl/tport_req_check.sv
module tport_req_check
    import phy_tport_pkg::*;
#(
    parameter int REQ_W = 16
) (
    input  logic [REQ_W-1:0]     addr,
    input  logic [REQ_W-1:0]     wdata,
    input  logic                 write,
    output logic                 bad,
    output logic [TP_BYTE_W-1:0] addr8,
    output logic [TP_BYTE_W-1:0] wdata8
);

    logic addr_over;
    logic data_over;

    always_comb begin
        addr_over = (addr >> TP_BYTE_W) != '0;
        data_over = write && ((wdata >> TP_BYTE_W) != '0);
        bad       = addr_over || data_over;
        addr8     = addr[TP_BYTE_W-1:0];
        wdata8    = wdata[TP_BYTE_W-1:0];
    end

endmodule

// File: rtl/tport_phase_timer.sv
module tport_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/tport_fsm.sv
module tport_fsm
    import phy_tport_pkg::*;
#(
    parameter int HALF_W   = 8,
    parameter int SETTLE_W = 8,
    parameter int CNT_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 write,
    input  logic                 bad,
    input  logic [TP_BYTE_W-1:0] addr8,
    input  logic [TP_BYTE_W-1:0] wdata8,
    input  logic                 clr_cmd,
    input  logic [HALF_W-1:0]    cfg_half,
    input  logic [SETTLE_W-1:0]  cfg_settle,
    input  logic                 tmr_expired,
    output logic                 tmr_load,
    output logic [CNT_W-1:0]     tmr_val,
    input  logic [TP_BYTE_W-1:0] tp_dout,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    output logic [TP_BYTE_W-1:0] rdata,
    output logic                 tp_clk,
    output logic                 tp_en,
    output logic [TP_BYTE_W-1:0] tp_din,
    output logic                 tp_clr
);

    typedef struct packed {
        tp_state_e            st;
        logic                 wr;
        logic [TP_BYTE_W-1:0] wdata;
        logic [CNT_W-1:0]     hm1;
        logic [CNT_W-1:0]     settle;
        logic                 tclk;
        logic                 ten;
        logic                 tclr;
        logic [TP_BYTE_W-1:0] din;
        logic [TP_BYTE_W-1:0] rdata;
        logic                 busy;
        logic                 done;
        logic                 err;
    } seq_t;

    seq_t             s_d, s_q;
    logic [CNT_W-1:0] half_ext;
    logic [CNT_W-1:0] hm1_new;

    always_comb begin
        half_ext = CNT_W'(cfg_half);
        hm1_new  = (half_ext == '0) ? '0 : half_ext - CNT_W'(1);
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (bad) begin
                        s_d.done = 1'b1;
                        s_d.err  = 1'b1;
                    end else begin
                        s_d.st     = ST_ADR_SETUP;
                        s_d.busy   = 1'b1;
                        s_d.wr     = write;
                        s_d.wdata  = wdata8;
                        s_d.din    = addr8;
                        s_d.ten    = 1'b1;
                        s_d.hm1    = hm1_new;
                        s_d.settle = CNT_W'(cfg_settle);
                    end
                end else if (clr_cmd) begin
                    s_d.st   = ST_CLR_LOW1;
                    s_d.busy = 1'b1;
                    s_d.hm1  = hm1_new;
                    tmr_load = 1'b1;
                    tmr_val  = hm1_new;
                end
            end
            ST_ADR_SETUP: begin
                s_d.tclk = 1'b1;
                s_d.st   = ST_ADR_HIGH;
                tmr_load = 1'b1;
                tmr_val  = s_q.hm1;
            end
            ST_ADR_HIGH: begin
                if (tmr_expired) begin
                    s_d.tclk = 1'b0;
                    s_d.st   = ST_ADR_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = s_q.hm1;
                end
            end
            ST_ADR_LOW: begin
                if (tmr_expired) begin
                    s_d.ten = 1'b0;
                    if (s_q.wr) begin
                        s_d.din = s_q.wdata;
                        s_d.st  = ST_DAT_SETUP;
                    end else begin
                        s_d.st   = ST_SETTLE;
                        tmr_load = 1'b1;
                        tmr_val  = s_q.settle;
                    end
                end
            end
            ST_DAT_SETUP: begin
                s_d.tclk = 1'b1;
                s_d.st   = ST_DAT_HIGH;
                tmr_load = 1'b1;
                tmr_val  = s_q.hm1;
            end
            ST_DAT_HIGH: begin
                if (tmr_expired) begin
                    s_d.tclk = 1'b0;
                    s_d.st   = ST_DAT_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = s_q.hm1;
                end
            end
            ST_DAT_LOW: begin
                if (tmr_expired) begin
                    s_d.st   = ST_IDLE;
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) begin
                    s_d.rdata = tp_dout;
                    s_d.st    = ST_IDLE;
                    s_d.busy  = 1'b0;
                    s_d.done  = 1'b1;
                end
            end
            ST_CLR_LOW1: begin
                if (tmr_expired) begin
                    s_d.tclr = 1'b1;
                    s_d.st   = ST_CLR_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = s_q.hm1;
                end
            end
            ST_CLR_HIGH: begin
                if (tmr_expired) begin
                    s_d.tclr = 1'b0;
                    s_d.st   = ST_CLR_LOW2;
                    tmr_load = 1'b1;
                    tmr_val  = s_q.hm1;
                end
            end
            ST_CLR_LOW2: begin
                if (tmr_expired) begin
                    s_d.st   = ST_IDLE;
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy   = s_q.busy;
    assign done   = s_q.done;
    assign err    = s_q.err;
    assign rdata  = s_q.rdata;
    assign tp_clk = s_q.tclk;
    assign tp_en  = s_q.ten;
    assign tp_din = s_q.din;
    assign tp_clr = s_q.tclr;

endmodule

// File: rtl/phy_tport_seq.sv
module phy_tport_seq
    import phy_tport_pkg::*;
#(
    parameter int REQ_W    = 16,
    parameter int HALF_W   = 8,
    parameter int SETTLE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_start,
    input  logic                 req_write,
    input  logic [REQ_W-1:0]     req_addr,
    input  logic [REQ_W-1:0]     req_wdata,
    input  logic                 clr_start,
    input  logic [HALF_W-1:0]    cfg_half,
    input  logic [SETTLE_W-1:0]  cfg_settle,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    output logic [TP_BYTE_W-1:0] rdata,
    output logic                 tp_clk,
    output logic                 tp_en,
    output logic [TP_BYTE_W-1:0] tp_din,
    input  logic [TP_BYTE_W-1:0] tp_dout,
    output logic                 tp_clr
);

    localparam int CNT_W = (HALF_W > SETTLE_W) ? HALF_W : SETTLE_W;

    logic                 bad;
    logic [TP_BYTE_W-1:0] addr8;
    logic [TP_BYTE_W-1:0] wdata8;
    logic                 tmr_load;
    logic [CNT_W-1:0]     tmr_val;
    logic                 tmr_expired;

    tport_req_check #(
        .REQ_W (REQ_W)
    ) u_check (
        .addr   (req_addr),
        .wdata  (req_wdata),
        .write  (req_write),
        .bad    (bad),
        .addr8  (addr8),
        .wdata8 (wdata8)
    );

    tport_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    tport_fsm #(
        .HALF_W   (HALF_W),
        .SETTLE_W (SETTLE_W),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (req_start),
        .write       (req_write),
        .bad         (bad),
        .addr8       (addr8),
        .wdata8      (wdata8),
        .clr_cmd     (clr_start),
        .cfg_half    (cfg_half),
        .cfg_settle  (cfg_settle),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .tp_dout     (tp_dout),
        .busy        (busy),
        .done        (done),
        .err         (err),
        .rdata       (rdata),
        .tp_clk      (tp_clk),
        .tp_en       (tp_en),
        .tp_din      (tp_din),
        .tp_clr      (tp_clr)
    );

endmodule

// File: rtl/tport_chk.sv
module tport_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_start,
    input logic       clr_start,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       tp_clk,
    input logic       tp_en,
    input logic [7:0] tp_din,
    input logic       tp_clr
);

    assert_setup_before_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tp_clk) |-> ($stable(tp_en) && $stable(tp_din)));

    assert_en_moves_clk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tp_en) || $fell(tp_en)) |-> !tp_clk);

    assert_clk_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tp_clk |-> busy);

    assert_clear_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tp_clr |-> (busy && !tp_clk && !tp_en));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tp_clk && !tp_en && !tp_clr));

    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    assert_busy_needs_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_start || clr_start));

endmodule

bind phy_tport_seq tport_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_start (req_start),
    .clr_start (clr_start),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .tp_clk    (tp_clk),
    .tp_en     (tp_en),
    .tp_din    (tp_din),
    .tp_clr    (tp_clr)
);

// File: tb/sim_phy_tport_seq.sv
`timescale 1ns/1ps
module sim_phy_tport_seq;

    localparam int PHY_LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        clr_start = 1'b0;
    logic [7:0]  cfg_half = 8'd1;
    logic [7:0]  cfg_settle = 8'd3;
    logic        busy, done, err;
    logic [7:0]  rdata;
    logic        tp_clk, tp_en, tp_clr;
    logic [7:0]  tp_din, tp_dout;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    phy_tport_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .clr_start(clr_start),
        .cfg_half(cfg_half), .cfg_settle(cfg_settle), .busy(busy), .done(done),
        .err(err), .rdata(rdata), .tp_clk(tp_clk), .tp_en(tp_en), .tp_din(tp_din),
        .tp_dout(tp_dout), .tp_clr(tp_clr)
    );

    // PHY model: enable high latches an address, enable low latches data
    logic [7:0] phy_mem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] ph_addr = 8'h00;
    int         low_cnt = 0;

    always @(posedge tp_clk) begin
        if (tp_en) ph_addr <= tp_din;
        else       phy_mem[ph_addr] <= tp_din;
    end

    always @(posedge clk) begin
        if (tp_en) low_cnt <= 0;
        else if (low_cnt < 1000) low_cnt <= low_cnt + 1;
    end

    assign tp_dout = (low_cnt >= PHY_LAT) ? phy_mem[ph_addr] : ~phy_mem[ph_addr];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // pin monitor: setup before each rise and high width
    int   cur_h = 1;
    int   pulses = 0;
    int   hi_len = 0;
    logic p_clk = 1'b0, p_en = 1'b0;
    logic [7:0] p_din = 8'h00;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tp_clk && !p_clk) begin
                pulses++;
                check(tp_en == p_en && tp_din == p_din, "R6 setup before rise",
                      {tp_en, tp_din}, {p_en, p_din});
            end
            if (tp_clk) hi_len++;
            if (!tp_clk && p_clk) begin
                check(hi_len == cur_h, "R5 high width", hi_len, cur_h);
                hi_len = 0;
            end
        end
        p_clk = tp_clk;
        p_en  = tp_en;
        p_din = tp_din;
    end

    int op_lat, clr_rise, clr_fall;
    bit busy_gap, op_err;
    logic [7:0] op_rd;

    // mode: 0 plain, 1 strobes while busy, 2 config change mid-access, 3 clear with start
    task automatic run_op(input bit is_wr, input bit is_clr, input logic [15:0] a,
                          input logic [15:0] d, input int h, input int s, input int mode);
        @(negedge clk);
        cfg_half   = 8'(h);
        cfg_settle = 8'(s);
        cur_h      = (h == 0) ? 1 : h;
        req_write  = is_wr;
        req_addr   = a;
        req_wdata  = d;
        req_start  = !is_clr;
        clr_start  = is_clr || (mode == 3);
        @(negedge clk);
        req_start = 1'b0;
        clr_start = 1'b0;
        op_lat = 0; clr_rise = -1; clr_fall = -1; busy_gap = 1'b0;
        while (!done && op_lat < 2000) begin
            @(negedge clk);
            op_lat++;
            if (tp_clr && clr_rise < 0) clr_rise = op_lat;
            if (!tp_clr && clr_rise >= 0 && clr_fall < 0) clr_fall = op_lat;
            if (!done && !busy) busy_gap = 1'b1;
            if (mode == 1 && op_lat == 2) begin
                req_start = 1'b1; req_write = 1'b1; req_addr = 16'h00EE;
                req_wdata = 16'h0011; clr_start = 1'b1;
            end else if (mode == 1 && op_lat == 3) begin
                req_start = 1'b0; clr_start = 1'b0;
            end
            if (mode == 2 && op_lat == 3) cfg_half = 8'(h + 3);
        end
        op_err = err;
        op_rd  = rdata;
    endtask

    task automatic after_done(input string req);
        @(negedge clk);
        check(!done && !busy, req, {done, busy}, 0);
    endtask

    function automatic int wr_lat(input int h);
        int he = (h == 0) ? 1 : h;
        return 2 + 4 * he;
    endfunction

    function automatic int rd_lat(input int h, input int s);
        int he = (h == 0) ? 1 : h;
        return 2 + 2 * he + s;
    endfunction

    function automatic logic [7:0] rd_exp(input logic [7:0] a, input int s);
        return (s >= PHY_LAT) ? exp_mem[a] : ~exp_mem[a];
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input int h, input int mode);
        logic [7:0] rd_before;
        rd_before = rdata;
        run_op(1'b1, 1'b0, {8'h00, a}, {8'h00, d}, h, 0, mode);
        exp_mem[a] = d;
        check(op_lat == wr_lat(h), "R3 write latency", op_lat, wr_lat(h));
        check(!op_err && !busy_gap, "R3 write no err, busy held", {op_err, busy_gap}, 0);
        check(op_rd == rd_before, "R10 rdata kept over write", op_rd, rd_before);
        after_done("R9 done single pulse after write");
    endtask

    task automatic do_read(input logic [7:0] a, input int h, input int s);
        logic [7:0] e;
        e = rd_exp(a, s);
        run_op(1'b0, 1'b0, {8'h00, a}, 16'h0000, h, s, 0);
        check(op_lat == rd_lat(h, s), "R4 read latency", op_lat, rd_lat(h, s));
        check(op_rd == e, "R4 read data", op_rd, e);
        check(!op_err, "R9 no err on good read", op_err, 0);
        after_done("R9 done single pulse after read");
    endtask

    initial begin
        int pulses0;
        logic [7:0] keep;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 256; i++) begin
            phy_mem[i] = 8'(i) ^ 8'h5A;
            exp_mem[i] = 8'(i) ^ 8'h5A;
        end
        repeat (4) @(negedge clk);
        check(!busy && !done && !err && rdata == 8'h00 && !tp_clk && !tp_en && !tp_clr,
              "R1 reset state", {busy, done, err, tp_clk, tp_en, tp_clr, rdata}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 / R4 directed write then read-back
        do_write(8'h10, 8'h3C, 1, 0);
        do_read(8'h10, 1, 3);
        check(rdata == 8'h3C, "R10 rdata holds after read", rdata, 8'h3C);
        // R4 short settle gives the unsettled value
        do_read(8'h10, 2, 1);
        do_read(8'h10, 3, 6);
        // R5 half width of zero counts as one
        do_write(8'h21, 8'hA5, 0, 0);
        do_read(8'h21, 0, 4);
        // R5 configuration captured at acceptance
        do_write(8'h22, 8'h7E, 2, 2);
        do_read(8'h22, 1, 3);

        // R7 clear sequence
        pulses0 = pulses;
        keep = rdata;
        run_op(1'b0, 1'b1, 16'h0000, 16'h0000, 2, 0, 0);
        check(clr_rise == 2, "R7 clear rises after H", clr_rise, 2);
        check(clr_fall == 4, "R7 clear falls after 2H", clr_fall, 4);
        check(op_lat == 6, "R7 clear done at 3H", op_lat, 6);
        check(pulses == pulses0, "R7 no test clock during clear", pulses, pulses0);
        check(rdata == keep, "R10 rdata kept over clear", rdata, keep);
        after_done("R9 done single pulse after clear");

        // R2 refused requests
        pulses0 = pulses;
        run_op(1'b0, 1'b0, 16'h01A3, 16'h0000, 1, 3, 0);
        check(op_lat == 0 && op_err, "R2 big address refused", {op_lat[7:0], op_err}, 1);
        check(!busy, "R2 busy stays low", busy, 0);
        check(op_rd == keep, "R10 rdata kept over refusal", op_rd, keep);
        after_done("R9 err pulse one cycle");
        run_op(1'b1, 1'b0, 16'h0030, 16'h01FF, 1, 0, 0);
        check(op_lat == 0 && op_err, "R2 big write data refused", {op_lat[7:0], op_err}, 1);
        check(pulses == pulses0, "R2 no pulses on refusal", pulses, pulses0);
        do_read(8'h30, 1, 3);

        // R8 strobes while busy ignored
        do_write(8'h40, 8'h99, 2, 1);
        do_read(8'hEE, 1, 3);
        do_read(8'h40, 1, 3);
        // R8 start wins over clear in the same cycle
        run_op(1'b1, 1'b0, 16'h0041, 16'h0066, 1, 0, 3);
        exp_mem[8'h41] = 8'h66;
        check(op_lat == wr_lat(1), "R8 start wins latency", op_lat, wr_lat(1));
        check(clr_rise < 0, "R8 clear untouched", clr_rise, -1);
        after_done("R9 done after simultaneous strobes");
        do_read(8'h41, 1, 3);

        // random mix
        for (int k = 0; k < 60; k++) begin
            logic [7:0] ra, rd;
            int rh, rs;
            ra = 8'($urandom_range(0, 255));
            rd = 8'($urandom_range(0, 255));
            rh = $urandom_range(0, 4);
            rs = $urandom_range(0, 6);
            if ($urandom_range(0, 1) == 1) do_write(ra, rd, rh, 0);
            else                           do_read(ra, rh, rs);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule